// File: doc/BRIEF.md
# Indirect-Addressed Parallel Host Port

This block connects an 8-bit asynchronous host bus to a device that holds many internal control registers. The host sees only four locations, chosen by a 2-bit select. Internal registers are reached in two steps. The host first writes a register index into the index location. It then reads or writes the data location, and that access moves data to or from the register at the stored index.

Two locations skip the index. One pops the next byte from an auxiliary receive FIFO. The other reads or clears the interrupt status register in a single access. A 256-entry register file, the FIFO storage, the interrupt status, mask and configuration registers, and the interrupt request pin driver are all part of the block.

All strobes are sampled on the block clock. An access starts on the first sampled cycle of a strobe while chip select is low.

Top module: `ihp_host_port`

## Requirements
- R1: After reset, the index register reads 00h, the interrupt status, mask and configuration registers are 00h, and the interrupt pin is released (not driven).
- R2: A write at select 00b loads the data byte as the internal register index. A read at select 00b returns the current index.
- R3: With the index set, a write at select 01b stores the byte in the register file at that index. A later read at select 01b returns it. Different indices hold independent values.
- R4: A read at select 10b returns the oldest byte in the FIFO and removes it, in a single access. Bytes come out in the order they were pushed.
- R5: A read at select 10b while the FIFO is empty returns 00h and leaves the FIFO unchanged, so a byte pushed afterwards is the next one returned.
- R6: Writing the interrupt status register, either at select 11b or through the data port at index C0h, clears each bit written as 1 and leaves each bit written as 0 unchanged. A read at select 11b returns the status.
- R7: A one-cycle pulse on a source input sets the matching status bit. If a source pulse and a host clear hit the same bit in the same cycle, the bit stays set.
- R8: The mask register sits at index C1h. The interrupt output is active (low) while any status bit with its mask bit set is 1, and inactive otherwise.
- R9: Bit 0 of the configuration register at index C2h selects the pin driver. When it is 0, the inactive interrupt pin is released (open drain). When it is 1, the inactive pin is driven high. The register reads back through the data port.
- R10: The acknowledge output is high-impedance whenever chip select is high. While selected, it rises one clock after a strobe is first sampled, so it is low at the first falling clock edge after the sampling edge and high at the second.
- R11: The data bus is driven by the block only during a read with chip select low. With chip select low and no strobe, the bus stays released.
- R12: The interrupt status register can be read through the data port at index C0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| hsel | input | 2 | Host location select: 00 index, 01 data, 10 FIFO, 11 status |
| hdata | inout | 8 | Bidirectional host data bus |
| hack | output | 1 | Transfer acknowledge; high-impedance while chip select is high |
| hirq_n | output | 1 | Interrupt request, active low; open-drain or push-pull |
| irq_src | input | 8 | Interrupt source pulses, one per status bit |
| fifo_push | input | 1 | Device-side FIFO write enable |
| fifo_din | input | 8 | Device-side FIFO write data |

## Verification
The host clear of a status bit and a source event setting that same bit can fall on the same clock edge. The bench provokes this by raising the source pulse one cycle after the write strobe is sampled. That places the pulse on exactly the edge where the clear is applied. It then reads the status at select 11b and expects the bit to still be set, and a second clear without a pulse must empty the bit. This shows that the earlier result came from the collision and not from a failed clear.

// File: rtl/ihp_pkg.sv
package ihp_pkg;

  typedef enum logic [1:0] {
    HP_INDEX  = 2'b00,
    HP_DATA   = 2'b01,
    HP_FIFO   = 2'b10,
    HP_STATUS = 2'b11
  } hp_sel_e;

  localparam logic [7:0] IDX_STATUS = 8'hC0;
  localparam logic [7:0] IDX_MASK   = 8'hC1;
  localparam logic [7:0] IDX_CFG    = 8'hC2;
  localparam int         CFG_PP_BIT = 0;

endpackage

// File: rtl/ihp_regfile.sv
module ihp_regfile #(
  parameter int DW = 8,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] mem [DEPTH];

  // synchronous write, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ihp_fifo.sv
module ihp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (empty && $stable(rd_ptr)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/ihp_irq_unit.sv
module ihp_irq_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] clr,
  input  logic          mask_we,
  input  logic          cfg_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] status,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] cfg,
  output logic          irq_act
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status  <= '0;
      mask    <= '0;
      cfg     <= '0;
      irq_act <= 1'b0;
    end else begin
      // a source event outranks a host clear on the same bit
      status  <= (status & ~clr) | src;
      irq_act <= |(status & mask);
      if (mask_we) mask <= wdata;
      if (cfg_we)  cfg  <= wdata;
    end
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (|src) |=> ((status & $past(src)) == $past(src)));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
    (|(clr & ~src)) |=> ((status & $past(clr & ~src)) == '0));

  assert_irq_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !(|(status & mask)) |=> !irq_act);
endmodule

// File: rtl/ihp_host_port.sv
module ihp_host_port #(
  parameter int DW         = 8,
  parameter int IW         = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    hsel,
  inout  wire  [DW-1:0] hdata,
  output wire           hack,
  output wire           hirq_n,
  input  logic [DW-1:0] irq_src,
  input  logic          fifo_push,
  input  logic [DW-1:0] fifo_din
);
  import ihp_pkg::*;

  localparam logic [IW-1:0] K_STATUS = IW'(IDX_STATUS);
  localparam logic [IW-1:0] K_MASK   = IW'(IDX_MASK);
  localparam logic [IW-1:0] K_CFG    = IW'(IDX_CFG);

  // sampled host pins
  logic          s_cs, s_rd, s_wr, rd_prev, wr_prev;
  hp_sel_e       s_sel;
  logic [DW-1:0] s_dat;
  logic          rd_live, wr_live, rd_go, wr_go;

  logic          ack_q, oe_q;
  logic [IW-1:0] index_q;
  logic [DW-1:0] rdata_q, rd_mux;

  logic          hit_st, hit_mask, hit_cfg, hit_any;
  logic          ram_we;
  logic [DW-1:0] ram_q;
  logic          fifo_pop, fifo_empty;
  logic [DW-1:0] fifo_head;
  logic [DW-1:0] clr_vec, status, mask, cfg;
  logic          mask_we, cfg_we, irq_act;

  assign rd_live = s_cs && s_rd;
  assign wr_live = s_cs && s_wr;
  assign rd_go   = rd_live && !rd_prev;
  assign wr_go   = wr_live && !wr_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_cs    <= 1'b0;
      s_rd    <= 1'b0;
      s_wr    <= 1'b0;
      s_sel   <= HP_INDEX;
      s_dat   <= '0;
      rd_prev <= 1'b0;
      wr_prev <= 1'b0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      s_cs    <= !cs_n;
      s_rd    <= !rd_n;
      s_wr    <= !wr_n;
      s_sel   <= hp_sel_e'(hsel);
      s_dat   <= hdata;
      rd_prev <= rd_live;
      wr_prev <= wr_live;
      ack_q   <= rd_live || wr_live;
      oe_q    <= rd_live;
    end
  end

  // decode of the indirect index
  assign hit_st   = (index_q == K_STATUS);
  assign hit_mask = (index_q == K_MASK);
  assign hit_cfg  = (index_q == K_CFG);
  assign hit_any  = hit_st || hit_mask || hit_cfg;

  always_comb begin
    clr_vec  = '0;
    ram_we   = 1'b0;
    mask_we  = 1'b0;
    cfg_we   = 1'b0;
    fifo_pop = 1'b0;
    if (wr_go) begin
      unique case (s_sel)
        HP_STATUS: clr_vec = s_dat;
        HP_DATA: begin
          if (hit_st) clr_vec = s_dat;
          mask_we = hit_mask;
          cfg_we  = hit_cfg;
          ram_we  = !hit_any;
        end
        default: ;
      endcase
    end
    if (rd_go && s_sel == HP_FIFO) fifo_pop = 1'b1;
  end

  always_comb begin
    unique case (s_sel)
      HP_INDEX: rd_mux = DW'(index_q);
      HP_DATA: begin
        if (hit_st)        rd_mux = status;
        else if (hit_mask) rd_mux = mask;
        else if (hit_cfg)  rd_mux = cfg;
        else               rd_mux = ram_q;
      end
      HP_FIFO:   rd_mux = fifo_empty ? '0 : fifo_head;
      HP_STATUS: rd_mux = status;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_go && s_sel == HP_INDEX) index_q <= IW'(s_dat);
      if (rd_go) rdata_q <= rd_mux;
    end
  end

  ihp_regfile #(.DW(DW), .IW(IW)) u_regs (
    .clk   (clk),
    .we    (ram_we),
    .waddr (index_q),
    .wdata (s_dat),
    .raddr (index_q),
    .rdata (ram_q)
  );

  ihp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (fifo_push),
    .din   (fifo_din),
    .pop   (fifo_pop),
    .head  (fifo_head),
    .empty (fifo_empty)
  );

  ihp_irq_unit #(.DW(DW)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .src     (irq_src),
    .clr     (clr_vec),
    .mask_we (mask_we),
    .cfg_we  (cfg_we),
    .wdata   (s_dat),
    .status  (status),
    .mask    (mask),
    .cfg     (cfg),
    .irq_act (irq_act)
  );

  // pin drivers
  assign hdata  = (oe_q && !cs_n && !rd_n) ? rdata_q : {DW{1'bz}};
  assign hack   = !cs_n ? ack_q : 1'bz;
  assign hirq_n = irq_act ? 1'b0 : (cfg[CFG_PP_BIT] ? 1'b1 : 1'bz);

  assert_bus_drive_R11: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> $past(!cs_n && !rd_n, 2));

  assert_ack_delay_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> $past(!cs_n && (!rd_n || !wr_n), 2));

  assert_index_load_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(index_q) |-> $past(wr_go && s_sel == HP_INDEX));
endmodule

// File: tb/ihp_host_port_test.sv
`timescale 1ns/100ps
module ihp_host_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] hsel = 2'b00;
  logic       tb_drv = 1'b0;
  logic [7:0] tb_dat = 8'h00;
  logic [7:0] irq_src = 8'h00;
  logic       fifo_push = 1'b0;
  logic [7:0] fifo_din = 8'h00;
  wire  [7:0] hdata;
  wire        hack;
  wire        hirq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic ack_s1, ack_s2, ack_s3;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  assign hdata = tb_drv ? tb_dat : 8'hzz;
  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup (hdata[i]);
  end
  pulldown (hack);
  pulldown (hirq_n);

  ihp_host_port uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .hsel(hsel), .hdata(hdata), .hack(hack), .hirq_n(hirq_n),
    .irq_src(irq_src), .fifo_push(fifo_push), .fifo_din(fifo_din)
  );

  // {is_read, sel[1:0], data[7:0], expected[7:0]}
  localparam int NV = 12;
  localparam logic [18:0] VEC [0:NV-1] = '{
    {1'b0, 2'b00, 8'h15, 8'h00},
    {1'b0, 2'b01, 8'hA7, 8'h00},
    {1'b0, 2'b00, 8'h80, 8'h00},
    {1'b0, 2'b01, 8'h3C, 8'h00},
    {1'b0, 2'b00, 8'h15, 8'h00},
    {1'b1, 2'b01, 8'h00, 8'hA7},   // R3 index 15h
    {1'b0, 2'b00, 8'h80, 8'h00},
    {1'b1, 2'b01, 8'h00, 8'h3C},   // R3 index 80h
    {1'b1, 2'b00, 8'h00, 8'h80},   // R2 index readback
    {1'b0, 2'b00, 8'hC1, 8'h00},
    {1'b0, 2'b01, 8'h0F, 8'h00},
    {1'b1, 2'b01, 8'h00, 8'h0F}    // R8 mask readback
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic host_cycle(input bit is_rd, input logic [1:0] a,
                            input logic [7:0] d, input logic [7:0] src,
                            output logic [7:0] q);
    @(negedge clk);
    hsel = a;
    cs_n = 1'b0;
    if (is_rd) rd_n = 1'b0;
    else begin wr_n = 1'b0; tb_drv = 1'b1; tb_dat = d; end
    @(negedge clk);
    ack_s1 = hack;
    irq_src = src;
    @(negedge clk);
    ack_s2 = hack;
    irq_src = 8'h00;
    @(negedge clk);
    q = hdata;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; tb_drv = 1'b0;
    #1 ack_s3 = hack;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] junk;
    host_cycle(1'b0, a, d, 8'h00, junk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] q);
    host_cycle(1'b1, a, 8'h00, 8'h00, q);
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk); fifo_push = 1'b1; fifo_din = v;
    @(negedge clk); fifo_push = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk); irq_src = v;
    @(negedge clk); irq_src = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired before the sequence finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq released", {7'b0, hirq_n}, 8'h00);
    chk("R10 ack released when unselected", {7'b0, hack}, 8'h00);
    chk("R11 bus idle", hdata, 8'hFF);
    rd(2'b00, rv); chk("R1 index", rv, 8'h00);
    rd(2'b11, rv); chk("R1 status", rv, 8'h00);
    wr(2'b00, 8'hC1); rd(2'b01, rv); chk("R1 mask", rv, 8'h00);
    wr(2'b00, 8'hC2); rd(2'b01, rv); chk("R1 config", rv, 8'h00);

    // R2/R3 vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) begin
        rd(VEC[i][17:16], rv);
        chk($sformatf("R2/R3 vector %0d", i), rv, VEC[i][7:0]);
      end else begin
        wr(VEC[i][17:16], VEC[i][15:8]);
      end
    end

    // R10 acknowledge timing and release
    rd(2'b00, rv);
    chk("R10 ack low one edge after sample", {7'b0, ack_s1}, 8'h00);
    chk("R10 ack high two edges after sample", {7'b0, ack_s2}, 8'h01);
    chk("R10 ack released at deselect", {7'b0, ack_s3}, 8'h00);

    // R11 selected without strobe leaves bus alone
    @(negedge clk); cs_n = 1'b0; hsel = 2'b01;
    repeat (3) @(negedge clk);
    chk("R11 bus released without strobe", hdata, 8'hFF);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 FIFO order
    push(8'h11); push(8'h22); push(8'h33);
    rd(2'b10, rv); chk("R4 fifo first", rv, 8'h11);
    rd(2'b10, rv); chk("R4 fifo second", rv, 8'h22);
    rd(2'b10, rv); chk("R4 fifo third", rv, 8'h33);

    // R5 empty read
    rd(2'b10, rv); chk("R5 empty returns zero", rv, 8'h00);
    push(8'h5A);
    rd(2'b10, rv); chk("R5 next byte after empty read", rv, 8'h5A);
    rd(2'b10, rv); chk("R5 empty again", rv, 8'h00);

    // R6 / R7 status set and clear
    pulse(8'h05);
    rd(2'b11, rv); chk("R7 source sets status", rv, 8'h05);
    wr(2'b11, 8'h01);
    rd(2'b11, rv); chk("R6 write-one clears", rv, 8'h04);
    host_cycle(1'b0, 2'b11, 8'h04, 8'h04, rv);
    rd(2'b11, rv); chk("R7 set wins over clear", rv, 8'h04);
    wr(2'b11, 8'h04);
    rd(2'b11, rv); chk("R6 clear without collision", rv, 8'h00);

    // R12 status through the data port, R6 clear there
    pulse(8'h80);
    wr(2'b00, 8'hC0);
    rd(2'b01, rv); chk("R12 status at C0h", rv, 8'h80);
    wr(2'b01, 8'h80);
    rd(2'b11, rv); chk("R6 clear via index C0h", rv, 8'h00);

    // R9 / R8 pin behaviour (mask 0Fh from table)
    wr(2'b00, 8'hC2); wr(2'b01, 8'h01);
    rd(2'b01, rv); chk("R9 config readback", rv, 8'h01);
    chk("R9 push-pull drives high", {7'b0, hirq_n}, 8'h01);
    pulse(8'h10);
    chk("R8 masked source inactive", {7'b0, hirq_n}, 8'h01);
    wr(2'b11, 8'h10);
    pulse(8'h02);
    chk("R8 enabled source active", {7'b0, hirq_n}, 8'h00);
    wr(2'b11, 8'h02);
    chk("R8 inactive after clear", {7'b0, hirq_n}, 8'h01);
    wr(2'b00, 8'hC2); wr(2'b01, 8'h00);
    chk("R9 open drain releases", {7'b0, hirq_n}, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule